// File: doc/BRIEF.md
# SPI NOR Flash Command Responder

This block is the slave side of a serial NOR flash. A host selects it and then hands it one byte per transfer strobe; the block returns one response byte for each transfer. The first byte after select is taken as a command opcode. The rest of the bytes in that select are its address, its dummy bytes or its data. Deselecting always ends the command. Storage is a small on-chip byte array. It powers up to 0xFF everywhere. Program and erase complete at once.

The supported commands are: ID read, normal read, fast read with 3-byte and 4-byte addresses, page program, chip erase, write-enable set and clear, and a two-step memory reset. Short responses, namely the ID and the response to an unknown opcode, come from a small output buffer that has position and length counters. An unknown opcode never stalls the host. It streams zero bytes until deselect.

Top module: `spi_nor_resp`

## Requirements
- R1: After reset rx_o is 0x00, wel_o, err_o and warn_o are 0, and every storage byte reads 0xFF.
- R2: Opcode 0x9F returns the ID_LEN configured ID bytes (lowest byte of ID_WORD first), then 0x00 bytes, for a fixed total of ID_MAX = 6 bytes. After the sixth byte the block is ready for a new opcode.
- R3: Any opcode not listed here makes every following byte of the same select return 0x00, however many bytes follow.
- R4: Opcode 0x03 takes 3 address bytes (most significant first) and then returns storage bytes from that address. The address increments per byte and wraps modulo 2**ADDR_W. Address bits above ADDR_W are dropped.
- R5: Opcode 0x0B takes 3 address bytes plus 1 dummy byte. Opcode 0x0C takes 4 address bytes plus 2 dummy bytes. The first data byte comes right after the last dummy byte.
- R6: Opcode 0x02 with write-enable set takes 3 address bytes and then ANDs each data byte into storage, with the address incrementing and wrapping. A data bit of 1 over a stored 0 leaves the 0 and sets the sticky warn_o.
- R7: Opcode 0x06 sets write-enable and opcode 0x04 clears it. Write-enable also clears at the deselect that ends a page program and when a chip erase runs.
- R8: Opcode 0xC7 or 0x60 with write-enable set fills storage with 0xFF. Without write-enable it has no effect on storage and sets the sticky err_o. Opcode 0x02 without write-enable is likewise ignored and sets err_o.
- R9: Opcode 0x66 arms a reset latch, and any other opcode disarms it. Opcode 0x99 with the latch armed clears write-enable, err_o and warn_o. Without the latch armed it does nothing.
- R10: Deasserting sel_i returns the block to waiting for an opcode and ends looping output. rx_valid_o stays low while deselected.
- R11: rx_o changes only in the cycle after an accepted transfer (sel_i and xfer_i high) and holds otherwise. rx_valid_o pulses exactly then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high |
| xfer_i | input | 1 | One-cycle strobe: tx_i holds a byte |
| tx_i | input | 8 | Byte from host |
| rx_o | output | 8 | Response byte for the last transfer |
| rx_valid_o | output | 1 | rx_o updated this cycle |
| wel_o | output | 1 | Write-enable state |
| err_o | output | 1 | Sticky: program or erase refused |
| warn_o | output | 1 | Sticky: a 0-to-1 program was attempted |

## Verification
Reads are done across the top of the address space, so address wrap shows up as data read from address 0. Programs use data that is first all-ones-compatible and then contains rising bits, which separates a plain write from an AND and shows whether the warning is raised. The reset-enable latch is tried both armed directly and disarmed by an intervening opcode. Unknown-opcode and ID streams run past their buffer length, which tells looping apart from returning to command decode.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
  localparam logic [7:0] OPC_ID     = 8'h9F;
  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_FREAD  = 8'h0B;
  localparam logic [7:0] OPC_FREAD4 = 8'h0C;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_WRDI   = 8'h04;
  localparam logic [7:0] OPC_ERASE  = 8'hC7;
  localparam logic [7:0] OPC_ERASE2 = 8'h60;
  localparam logic [7:0] OPC_RSTEN  = 8'h66;
  localparam logic [7:0] OPC_RSTMEM = 8'h99;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DUMMY, ST_READ, ST_PROG, ST_DOUT
  } st_e;

  typedef enum logic [3:0] {
    OP_ID, OP_READ, OP_PROG, OP_WREN, OP_WRDI, OP_ERASE,
    OP_RSTEN, OP_RSTMEM, OP_UNKNOWN
  } op_e;
endpackage

// File: rtl/spi_nor_cmd_dec.sv
module spi_nor_cmd_dec
  import spi_nor_pkg::*;
(
  input  logic [7:0] opc_i,
  output op_e        cls_o,
  output logic [2:0] abytes_o,
  output logic [1:0] dummy_o
);
  always_comb begin
    cls_o    = OP_UNKNOWN;
    abytes_o = 3'd3;
    dummy_o  = 2'd0;
    case (opc_i)
      OPC_ID:     cls_o = OP_ID;
      OPC_READ:   cls_o = OP_READ;
      OPC_FREAD:  begin cls_o = OP_READ; dummy_o = 2'd1; end
      OPC_FREAD4: begin cls_o = OP_READ; dummy_o = 2'd2; abytes_o = 3'd4; end
      OPC_PROG:   cls_o = OP_PROG;
      OPC_WREN:   cls_o = OP_WREN;
      OPC_WRDI:   cls_o = OP_WRDI;
      OPC_ERASE, OPC_ERASE2: cls_o = OP_ERASE;
      OPC_RSTEN:  cls_o = OP_RSTEN;
      OPC_RSTMEM: cls_o = OP_RSTMEM;
      default:    cls_o = OP_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/spi_nor_store.sv
module spi_nor_store #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= 8'hFF;
      else if (erase_i)                     mem_q[g] <= 8'hFF;
      else if (we_i && addr_i == AW'(g))    mem_q[g] <= mem_q[g] & wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/spi_nor_outbuf.sv
module spi_nor_outbuf #(
  parameter int              MAX_LEN = 6,
  parameter int              ID_LEN  = 3,
  parameter logic [8*MAX_LEN-1:0] ID_WORD = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_id_i,
  input  logic       load_zero_i,
  input  logic       adv_i,
  input  logic       rel_i,
  output logic [7:0] byte_o,
  output logic       last_o
);
  localparam int PW = $clog2(MAX_LEN + 1);

  logic [7:0]    buf_q [MAX_LEN];
  logic [PW-1:0] len_q, pos_q;
  logic          loop_q;
  logic          wrap;

  assign wrap   = (pos_q + PW'(1)) == len_q;
  assign byte_o = buf_q[pos_q];
  assign last_o = wrap && !loop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= 8'h00;
      len_q  <= PW'(1);
      pos_q  <= '0;
      loop_q <= 1'b0;
    end else if (rel_i) begin
      pos_q  <= '0;
      loop_q <= 1'b0;
    end else if (load_id_i) begin
      for (int i = 0; i < MAX_LEN; i++)
        buf_q[i] <= (i < ID_LEN) ? ID_WORD[8*i +: 8] : 8'h00;
      len_q  <= PW'(MAX_LEN);
      pos_q  <= '0;
      loop_q <= 1'b0;
    end else if (load_zero_i) begin
      buf_q[0] <= 8'h00;
      len_q    <= PW'(1);
      pos_q    <= '0;
      loop_q   <= 1'b1;
    end else if (adv_i) begin
      pos_q <= wrap ? '0 : pos_q + PW'(1);
    end
  end
endmodule

// File: rtl/spi_nor_resp.sv
module spi_nor_resp
  import spi_nor_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          ID_MAX  = 6,
  parameter int          ID_LEN  = 3,
  parameter logic [8*ID_MAX-1:0] ID_WORD = 48'h0000_0019_BA20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       xfer_i,
  input  logic [7:0] tx_i,
  output logic [7:0] rx_o,
  output logic       rx_valid_o,
  output logic       wel_o,
  output logic       err_o,
  output logic       warn_o
);
  st_e               st_q;
  op_e               cls;
  logic [2:0]        abytes;
  logic [1:0]        dummy;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        cnt_q;
  logic [1:0]        dum_q;
  logic              is_prog_q;
  logic              wel_q, rst_en_q, err_q, warn_q, rxv_q;
  logic [7:0]        rx_q, rdata, ob_byte;
  logic              ob_last;
  logic              xfer, in_idle;

  assign xfer    = sel_i && xfer_i;
  assign in_idle = xfer && st_q == ST_IDLE;

  spi_nor_cmd_dec u_dec (
    .opc_i(tx_i), .cls_o(cls), .abytes_o(abytes), .dummy_o(dummy)
  );

  spi_nor_store #(.AW(ADDR_W)) u_store (
    .clk_i, .rst_ni,
    .erase_i(in_idle && cls == OP_ERASE && wel_q),
    .we_i   (xfer && st_q == ST_PROG),
    .addr_i (addr_q),
    .wdata_i(tx_i),
    .rdata_o(rdata)
  );

  spi_nor_outbuf #(.MAX_LEN(ID_MAX), .ID_LEN(ID_LEN), .ID_WORD(ID_WORD)) u_obuf (
    .clk_i, .rst_ni,
    .load_id_i  (in_idle && cls == OP_ID),
    .load_zero_i(in_idle && cls == OP_UNKNOWN),
    .adv_i      (xfer && st_q == ST_DOUT),
    .rel_i      (!sel_i),
    .byte_o     (ob_byte),
    .last_o     (ob_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      dum_q     <= '0;
      is_prog_q <= 1'b0;
      wel_q     <= 1'b0;
      rst_en_q  <= 1'b0;
      err_q     <= 1'b0;
      warn_q    <= 1'b0;
      rx_q      <= 8'h00;
      rxv_q     <= 1'b0;
    end else begin
      rxv_q <= xfer;
      if (!sel_i) begin
        st_q <= ST_IDLE;
        if (st_q == ST_PROG) wel_q <= 1'b0;  // program completes at deselect
      end else if (xfer_i) begin
        rx_q <= 8'h00;
        case (st_q)
          ST_IDLE: begin
            rst_en_q <= (cls == OP_RSTEN);
            case (cls)
              OP_ID, OP_UNKNOWN: st_q <= ST_DOUT;
              OP_READ: begin
                is_prog_q <= 1'b0;
                cnt_q     <= abytes - 3'd1;
                dum_q     <= dummy;
                st_q      <= ST_ADDR;
              end
              OP_PROG: begin
                if (wel_q) begin
                  is_prog_q <= 1'b1;
                  cnt_q     <= abytes - 3'd1;
                  dum_q     <= 2'd0;
                  st_q      <= ST_ADDR;
                end else err_q <= 1'b1;
              end
              OP_WREN:  wel_q <= 1'b1;
              OP_WRDI:  wel_q <= 1'b0;
              OP_ERASE: if (wel_q) wel_q <= 1'b0; else err_q <= 1'b1;
              OP_RSTMEM: if (rst_en_q) begin
                wel_q  <= 1'b0;
                err_q  <= 1'b0;
                warn_q <= 1'b0;
              end
              default: ;
            endcase
          end
          ST_ADDR: begin
            addr_q <= ADDR_W'({addr_q, tx_i});
            if (cnt_q == 3'd0)
              st_q <= is_prog_q ? ST_PROG : (dum_q != 2'd0 ? ST_DUMMY : ST_READ);
            else
              cnt_q <= cnt_q - 3'd1;
          end
          ST_DUMMY: begin
            if (dum_q == 2'd1) st_q <= ST_READ;
            dum_q <= dum_q - 2'd1;
          end
          ST_READ: begin
            rx_q   <= rdata;
            addr_q <= addr_q + ADDR_W'(1);
          end
          ST_PROG: begin
            if ((~rdata & tx_i) != 8'h00) warn_q <= 1'b1;
            addr_q <= addr_q + ADDR_W'(1);
          end
          ST_DOUT: begin
            rx_q <= ob_byte;
            if (ob_last) st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rx_o       = rx_q;
  assign rx_valid_o = rxv_q;
  assign wel_o      = wel_q;
  assign err_o      = err_q;
  assign warn_o     = warn_q;
endmodule

// File: rtl/spi_nor_resp_chk.sv
module spi_nor_resp_chk
  import spi_nor_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       xfer_i,
  input logic [7:0] tx_i,
  input logic [7:0] rx_o,
  input logic       rx_valid_o,
  input logic       wel_o,
  input logic       err_o,
  input logic       warn_o
);
  // R11
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i && xfer_i) |-> $stable(rx_o));

  // R11
  rx_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(sel_i && xfer_i));

  // R10
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !rx_valid_o);

  // R7
  wel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> $past(sel_i && xfer_i && tx_i == OPC_WREN));

  // R8
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(sel_i && xfer_i &&
      (tx_i == OPC_ERASE || tx_i == OPC_ERASE2 || tx_i == OPC_PROG)));

  // R9
  err_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(sel_i && xfer_i && tx_i == OPC_RSTMEM));

  // R9
  warn_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(warn_o) |-> $past(sel_i && xfer_i && tx_i == OPC_RSTMEM));

  // R6
  warn_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_o) |-> $past(sel_i && xfer_i));
endmodule

bind spi_nor_resp spi_nor_resp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .xfer_i(xfer_i),
  .tx_i(tx_i), .rx_o(rx_o), .rx_valid_o(rx_valid_o), .wel_o(wel_o),
  .err_o(err_o), .warn_o(warn_o)
);

// File: tb/spi_nor_resp_test.sv
module spi_nor_resp_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0;
  logic       xfer_i = 1'b0;
  logic [7:0] tx_i = 8'h00;
  logic [7:0] rx_o;
  logic       rx_valid_o, wel_o, err_o, warn_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  spi_nor_resp uut (
    .clk_i, .rst_ni, .sel_i, .xfer_i, .tx_i,
    .rx_o, .rx_valid_o, .wel_o, .err_o, .warn_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xb(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk_i);
    sel_i = 1'b1; xfer_i = 1'b1; tx_i = b;
    @(negedge clk_i);
    xfer_i = 1'b0;
    r = rx_o;
    check("R11", {7'd0, rx_valid_o}, 8'd1);
  endtask

  task automatic xn(input logic [7:0] b);
    logic [7:0] r;
    xb(b, r);
  endtask

  task automatic desel();
    @(negedge clk_i);
    sel_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R10", {7'd0, rx_valid_o}, 8'd0);
  endtask

  task automatic rd_byte(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] r;
    xn(8'h03); xn(8'h00); xn(8'h00); xn(a);
    xb(8'h00, r);
    check(req, r, exp);
    desel();
  endtask

  task automatic t_reset();
    check("R1", rx_o, 8'h00);
    check("R1", {5'd0, wel_o, err_o, warn_o}, 8'h00);
    rd_byte(8'h10, 8'hFF, "R1");
  endtask

  task automatic t_id();
    logic [7:0] r;
    logic [7:0] exp [6] = '{8'h20, 8'hBA, 8'h19, 8'h00, 8'h00, 8'h00};
    xn(8'h9F);
    for (int i = 0; i < 6; i++) begin
      xb(8'h00, r);
      check("R2", r, exp[i]);
    end
    xn(8'h06);  // decoded as a new opcode after the sixth byte
    check("R2", {7'd0, wel_o}, 8'd1);
    xn(8'h04);
    desel();
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    xn(8'hAB);
    for (int i = 0; i < 5; i++) begin
      xb(8'h9F, r);
      check("R3", r, 8'h00);
    end
    check("R3", {7'd0, wel_o}, 8'd0);
    xn(8'h06);  // still streaming, not decoded
    check("R3", {7'd0, wel_o}, 8'd0);
    desel();
    xn(8'h9F);
    xb(8'h00, r);
    check("R10", r, 8'h20);
    desel();
  endtask

  task automatic t_prog_noen();
    xn(8'h02); xn(8'h00); xn(8'h00); xn(8'h05);
    xn(8'h00);
    desel();
    check("R8", {7'd0, err_o}, 8'd1);
    rd_byte(8'h05, 8'hFF, "R8");
    xn(8'h66); xn(8'h99);
    desel();
    check("R9", {7'd0, err_o}, 8'd0);
  endtask

  task automatic t_prog();
    logic [7:0] r;
    xn(8'h06);
    check("R7", {7'd0, wel_o}, 8'd1);
    xn(8'h04);
    check("R7", {7'd0, wel_o}, 8'd0);
    xn(8'h06);
    desel();
    xn(8'h02); xn(8'h00); xn(8'h00); xn(8'hFE);
    xn(8'h5A); xn(8'hC3); xn(8'h0F);
    check("R7", {7'd0, wel_o}, 8'd1);
    desel();
    check("R7", {7'd0, wel_o}, 8'd0);
    check("R6", {7'd0, warn_o}, 8'd0);
    xn(8'h03); xn(8'h00); xn(8'h00); xn(8'hFE);
    xb(8'h00, r); check("R4", r, 8'h5A);
    xb(8'h00, r); check("R4", r, 8'hC3);
    xb(8'h00, r); check("R4", r, 8'h0F);  // wrapped to address 0
    desel();
    xn(8'h06); xn(8'h02); xn(8'h00); xn(8'h00); xn(8'hFE);
    xn(8'hF0);
    desel();
    check("R6", {7'd0, warn_o}, 8'd1);
    rd_byte(8'hFE, 8'h50, "R6");
  endtask

  task automatic t_fast();
    logic [7:0] r;
    xn(8'h0B); xn(8'h00); xn(8'h00); xn(8'hFE);
    xb(8'hFF, r); check("R5", r, 8'h00);
    xb(8'h00, r); check("R5", r, 8'h50);
    desel();
    xn(8'h0C); xn(8'h00); xn(8'h00); xn(8'h00); xn(8'hFF);
    xn(8'hFF); xn(8'hFF);
    xb(8'h00, r); check("R5", r, 8'hC3);
    xb(8'h00, r); check("R5", r, 8'h0F);
    desel();
  endtask

  task automatic t_erase();
    xn(8'hC7);
    desel();
    check("R8", {7'd0, err_o}, 8'd1);
    rd_byte(8'hFE, 8'h50, "R8");
    xn(8'h66); xn(8'h04); xn(8'h99);
    desel();
    check("R9", {6'd0, err_o, warn_o}, 8'h03);
    xn(8'h99);
    desel();
    check("R9", {6'd0, err_o, warn_o}, 8'h03);
    xn(8'h06); xn(8'h66); xn(8'h99);
    desel();
    check("R9", {5'd0, wel_o, err_o, warn_o}, 8'h00);
    xn(8'h06); xn(8'h60);
    check("R7", {7'd0, wel_o}, 8'd0);
    desel();
    rd_byte(8'hFE, 8'hFF, "R8");
    rd_byte(8'h00, 8'hFF, "R8");
    check("R8", {7'd0, err_o}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_id();
    t_unknown();
    t_prog_noen();
    t_prog();
    t_fast();
    t_erase();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule